// File: doc/BRIEF.md
# Dual-Protocol Serial Write Receiver

This block is the write-only serial front end of an on-screen-display controller. A host sends bytes over a three-wire SPI-style link or over I2C, and a mode input picks which of the two is live. The receiver samples the serial lines into the system clock domain and shifts each byte in most significant bit first. It hands every completed byte to a downstream packet parser as a one-cycle valid pulse with the byte value.

It also produces frame-start and frame-end markers, so the parser can clear its state between packets. In SPI mode a frame runs from the falling to the rising edge of an active-low select line. In I2C mode a frame runs from a START to a STOP, and a repeated START closes one frame and opens the next. The I2C side answers one fixed device address and pulls the data line low to acknowledge each byte it accepts. It ignores traffic sent to any other address. It never drives data back to the host.

Top module: `osd_serial_rx`

## Requirements
- R1: While reset is asserted, and in the cycles after it before any bus activity, byte_valid_o, frame_start_o, frame_end_o and sda_oe_o are low.
- R2: With i2c_mode_i low, a falling edge on ssb_i gives one frame_start_o pulse. A rising edge that ends an open frame gives one frame_end_o pulse.
- R3: With i2c_mode_i low and ssb_i low, sda_i is sampled on each rising edge of sck_i. Every eighth sample completes a byte, presented on byte_data_o with the first sampled bit at bit 7. A frame may hold any number of bytes.
- R4: In SPI mode, bits still pending when ssb_i rises are dropped. Clock edges while ssb_i is high produce no byte.
- R5: With i2c_mode_i high, a START (sda_i falling while sck_i is high) gives one frame_start_o pulse. A STOP (sda_i rising while sck_i is high) ends an open frame with one frame_end_o pulse.
- R6: In I2C mode, an address byte of 0x7A (device address 0x3D, write bit 0) is acknowledged. Each following byte is output on byte_data_o and acknowledged. An acknowledge means sda_oe_o is high through the ninth clock pulse of that byte.
- R7: In I2C mode, any other address byte, including 0x7B, is not acknowledged. No byte is output and sda_oe_o stays low until the next START.
- R8: A repeated START inside an I2C frame gives a frame_end_o pulse and a frame_start_o pulse in the same cycle, and begins a new address phase.
- R9: The inactive protocol has no effect. In I2C mode, select-line framing produces no pulse. In SPI mode, START patterns on the lines produce no pulse and sda_oe_o stays low.
- R10: byte_valid_o, frame_start_o and frame_end_o are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i2c_mode_i | input | 1 | 1 selects I2C, 0 selects SPI |
| ssb_i | input | 1 | Active-low SPI select |
| sck_i | input | 1 | Serial clock (SPI clock or I2C SCL) |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull data line low (I2C acknowledge) |
| byte_valid_o | output | 1 | One-cycle pulse per received byte |
| byte_data_o | output | 8 | Received byte, first bit at MSB |
| frame_start_o | output | 1 | One-cycle frame-open pulse |
| frame_end_o | output | 1 | One-cycle frame-close pulse |

## Verification
Every cycle, the assertions check three things: the output pulses last exactly one cycle, an SPI byte or frame end appears only inside an open select frame, and an I2C byte comes only from the data phase of a matched address, never while skipping a foreign address. Several behaviours depend on the bus scenario as a whole, so only the bench's scenarios can show them. These are bit order, byte counts over long and truncated frames, the acknowledge level seen on the wired line in the ninth clock, the same-cycle frame markers at a repeated START, and the silence of the inactive protocol.

// File: rtl/osd_rx_pkg.sv
`timescale 1ns/1ps
package osd_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_LANES = 3;
  localparam int LANE_SSB = 0;
  localparam int LANE_SCK = 1;
  localparam int LANE_SDA = 2;

  typedef enum logic [1:0] {
    I2C_IDLE,
    I2C_ADDR,
    I2C_DATA,
    I2C_SKIP
  } i2c_state_e;
endpackage

// File: rtl/osd_rx_sync.sv
`timescale 1ns/1ps
module osd_rx_sync #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o
);
  logic [LANES-1:0] stg [STAGES];
  logic [LANES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '1;
    else         stg[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else         stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= stg[STAGES-1];
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
  assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/osd_rx_spi.sv
`timescale 1ns/1ps
module osd_rx_spi
  import osd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ssb_rise_i,
  input  logic              ssb_fall_i,
  input  logic              sck_rise_i,
  input  logic              sda_lvl_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q, data_q;
  logic              bv_q, fs_q, fe_q;
  logic [BYTE_W-1:0] shift_nx;

  assign shift_nx = {shift_q[BYTE_W-2:0], sda_lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; cnt_q <= '0; shift_q <= '0; data_q <= '0;
      bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0; cnt_q <= '0;
      bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
      if (ssb_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        fs_q     <= 1'b1;
      end else if (ssb_rise_i) begin
        fe_q     <= active_q;
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q && sck_rise_i) begin
        shift_q <= shift_nx;
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          cnt_q  <= '0;
          data_q <= shift_nx;
          bv_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_valid_o  = bv_q;
  assign byte_data_o   = data_q;
  assign frame_start_o = fs_q;
  assign frame_end_o   = fe_q;

  assert_spi_byte_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bv_q |-> $past(active_q));
  assert_spi_end_after_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_q |-> $past(active_q));
endmodule

// File: rtl/osd_rx_i2c.sv
`timescale 1ns/1ps
module osd_rx_i2c
  import osd_rx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              sda_oe_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  i2c_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q, data_q;
  logic              arm_q, oe_q, bv_q, fs_q, fe_q;
  logic              start_c, stop_c;
  logic [BYTE_W-1:0] shift_nx;

  assign start_c  = scl_lvl_i & sda_fall_i;
  assign stop_c   = scl_lvl_i & sda_rise_i;
  assign shift_nx = {shift_q[BYTE_W-2:0], sda_lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= I2C_IDLE; cnt_q <= '0; shift_q <= '0; data_q <= '0;
      arm_q <= 1'b0; oe_q <= 1'b0; bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= I2C_IDLE; cnt_q <= '0; arm_q <= 1'b0; oe_q <= 1'b0;
      bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      bv_q <= 1'b0; fs_q <= 1'b0; fe_q <= 1'b0;
      if (start_c) begin
        fe_q    <= (state_q != I2C_IDLE);
        fs_q    <= 1'b1;
        state_q <= I2C_ADDR;
        cnt_q   <= '0;
        arm_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_c) begin
        fe_q    <= (state_q != I2C_IDLE);
        state_q <= I2C_IDLE;
        cnt_q   <= '0;
        arm_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        if (scl_rise_i && state_q != I2C_IDLE) begin
          if (cnt_q == CNT_W'(BYTE_W)) begin
            cnt_q <= '0;   // acknowledge clock
          end else begin
            shift_q <= shift_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W-1)) begin
              unique case (state_q)
                I2C_ADDR: begin
                  if (shift_nx == ADDR_WR) begin
                    state_q <= I2C_DATA;
                    arm_q   <= 1'b1;
                  end else begin
                    state_q <= I2C_SKIP;
                  end
                end
                I2C_DATA: begin
                  data_q <= shift_nx;
                  bv_q   <= 1'b1;
                  arm_q  <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        end
        if (scl_fall_i) begin
          oe_q  <= arm_q;   // drive through the ninth clock, release after it
          arm_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe_o      = oe_q;
  assign byte_valid_o  = bv_q;
  assign byte_data_o   = data_q;
  assign frame_start_o = fs_q;
  assign frame_end_o   = fe_q;

  assert_no_ack_when_skipping_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == I2C_SKIP) |-> !oe_q);
  assert_byte_from_data_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bv_q |-> ($past(state_q) == I2C_DATA));
  assert_no_ack_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == I2C_IDLE) |-> !oe_q);
endmodule

// File: rtl/osd_serial_rx.sv
`timescale 1ns/1ps
module osd_serial_rx
  import osd_rx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i2c_mode_i,
  input  logic              ssb_i,
  input  logic              sck_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);
  logic [N_LANES-1:0] raw, lvl, rise, fall;
  logic              spi_bv, spi_fs, spi_fe;
  logic [BYTE_W-1:0] spi_data;
  logic              i2c_bv, i2c_fs, i2c_fe, i2c_oe;
  logic [BYTE_W-1:0] i2c_data;

  always_comb begin
    raw = '1;
    raw[LANE_SSB] = ssb_i;
    raw[LANE_SCK] = sck_i;
    raw[LANE_SDA] = sda_i;
  end

  osd_rx_sync #(.LANES(N_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .raw_i(raw), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  osd_rx_spi u_spi (
    .clk_i, .rst_ni,
    .en_i          (!i2c_mode_i),
    .ssb_rise_i    (rise[LANE_SSB]),
    .ssb_fall_i    (fall[LANE_SSB]),
    .sck_rise_i    (rise[LANE_SCK]),
    .sda_lvl_i     (lvl[LANE_SDA]),
    .byte_valid_o  (spi_bv),
    .byte_data_o   (spi_data),
    .frame_start_o (spi_fs),
    .frame_end_o   (spi_fe)
  );

  osd_rx_i2c #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk_i, .rst_ni,
    .en_i          (i2c_mode_i),
    .scl_lvl_i     (lvl[LANE_SCK]),
    .scl_rise_i    (rise[LANE_SCK]),
    .scl_fall_i    (fall[LANE_SCK]),
    .sda_lvl_i     (lvl[LANE_SDA]),
    .sda_rise_i    (rise[LANE_SDA]),
    .sda_fall_i    (fall[LANE_SDA]),
    .sda_oe_o      (i2c_oe),
    .byte_valid_o  (i2c_bv),
    .byte_data_o   (i2c_data),
    .frame_start_o (i2c_fs),
    .frame_end_o   (i2c_fe)
  );

  assign sda_oe_o      = i2c_mode_i & i2c_oe;
  assign byte_valid_o  = i2c_mode_i ? i2c_bv   : spi_bv;
  assign byte_data_o   = i2c_mode_i ? i2c_data : spi_data;
  assign frame_start_o = i2c_mode_i ? i2c_fs   : spi_fs;
  assign frame_end_o   = i2c_mode_i ? i2c_fe   : spi_fe;

  assert_byte_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
  assert_start_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  assert_end_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);
endmodule

// File: tb/osd_serial_rx_test.sv
`timescale 1ns/1ps
module osd_serial_rx_test;
  localparam int HP = 10; // system clocks per serial half period

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic ssb = 1'b1, sck = 1'b1, sda_h = 1'b1;
  logic sda_line, sda_oe, bv, fs, fe;
  logic [7:0] bdata;

  always #10 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  osd_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .i2c_mode_i(mode), .ssb_i(ssb), .sck_i(sck),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .byte_valid_o(bv), .byte_data_o(bdata),
    .frame_start_o(fs), .frame_end_o(fe)
  );

  int checks = 0, fails = 0, done = 0;
  int n_bytes = 0, n_fs = 0, n_fe = 0, n_both = 0, wide = 0, spi_oe = 0;
  logic [7:0] log_b [16];
  logic bv_p = 0, fs_p = 0, fe_p = 0;
  logic [7:0] tx [16];

  always @(negedge clk) begin
    if (bv) begin if (n_bytes < 16) log_b[n_bytes] = bdata; n_bytes++; end
    if (fs) n_fs++;
    if (fe) n_fe++;
    if (fs && fe) n_both++;
    if ((bv && bv_p) || (fs && fs_p) || (fe && fe_p)) wide++;
    if (!mode && sda_oe) spi_oe++;
    bv_p = bv; fs_p = fs; fe_p = fe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic clr();
    @(posedge clk); n_bytes = 0; n_fs = 0; n_fe = 0; n_both = 0;
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; sda_h = b[i]; wt(HP); sck = 1'b1; wt(HP);
    end
    sck = 1'b0;
  endtask

  task automatic spi_frame(input int n);
    ssb = 1'b0; sck = 1'b0; wt(HP);
    for (int k = 0; k < n; k++) spi_bits(tx[k], 8);
    wt(HP); ssb = 1'b1; wt(HP);
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; wt(HP); sck = 1'b1; wt(HP); sda_h = 1'b0; wt(HP); sck = 1'b0; wt(HP);
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; wt(HP); sck = 1'b1; wt(HP); sda_h = 1'b1; wt(HP);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wt(HP); sck = 1'b1; wt(HP); sck = 1'b0;
    end
    sda_h = 1'b1; wt(HP); sck = 1'b1; wt(HP / 2);
    ack = ~sda_line; wt(HP / 2); sck = 1'b0;
  endtask

  // {mode, first byte, three data bytes}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 8'h7A, 8'h81, 8'h3C, 8'hFF},
    {1'b1, 8'h7B, 8'h11, 8'h22, 8'h33},
    {1'b1, 8'h3D, 8'h7A, 8'h7A, 8'h7A},
    {1'b0, 8'hA5, 8'h01, 8'h80, 8'h7E},
    {1'b0, 8'h7A, 8'h00, 8'hFF, 8'h5A},
    {1'b1, 8'h7A, 8'h00, 8'h55, 8'hAA}
  };

  initial begin
    logic a;
    int acks;
    bit match;
    wt(5);
    chk(!bv && !fs && !fe && !sda_oe, "R1 reset outputs", {bv, fs, fe, sda_oe}, 0);
    rst_n = 1'b1; wt(10);
    chk(!bv && !fs && !fe && !sda_oe && n_fs == 0, "R1 idle after reset", n_fs, 0);

    foreach (VEC[v]) begin
      mode = VEC[v][32]; ssb = 1'b1; sck = mode; sda_h = 1'b1; wt(2 * HP);
      for (int k = 0; k < 4; k++) tx[k] = VEC[v][31 - 8 * k -: 8];
      clr();
      if (mode) begin
        match = (tx[0] == 8'h7A); acks = 0;
        i2c_start();
        for (int k = 0; k < 4; k++) begin i2c_byte(tx[k], a); acks += a; end
        i2c_stop(); wt(HP);
        chk(acks == (match ? 4 : 0), match ? "R6 acks" : "R7 no acks", acks, match ? 4 : 0);
        chk(n_bytes == (match ? 3 : 0), match ? "R6 byte count" : "R7 bytes dropped",
            n_bytes, match ? 3 : 0);
        if (match) for (int k = 0; k < 3; k++)
          chk(log_b[k] == tx[k + 1], "R6 data", log_b[k], tx[k + 1]);
        chk(n_fs == 1 && n_fe == 1, "R5 frame markers", n_fs * 10 + n_fe, 11);
      end else begin
        spi_frame(4);
        chk(n_bytes == 4, "R3 byte count", n_bytes, 4);
        for (int k = 0; k < 4; k++) chk(log_b[k] == tx[k], "R3 msb first data", log_b[k], tx[k]);
        chk(n_fs == 1 && n_fe == 1, "R2 frame markers", n_fs * 10 + n_fe, 11);
      end
    end

    // R3 long packet
    mode = 1'b0; sck = 1'b0; wt(2 * HP); clr();
    for (int k = 0; k < 12; k++) tx[k] = 8'(k * 37 + 3);
    spi_frame(12);
    chk(n_bytes == 12, "R3 long packet", n_bytes, 12);
    chk(log_b[11] == tx[11], "R3 last byte", log_b[11], tx[11]);

    // R4 truncated byte, clocks outside frame
    clr();
    ssb = 1'b0; wt(HP); spi_bits(8'hC3, 8); spi_bits(8'hFF, 3); wt(HP); ssb = 1'b1; wt(HP);
    chk(n_bytes == 1 && log_b[0] == 8'hC3, "R4 partial dropped", n_bytes, 1);
    clr();
    spi_bits(8'hAA, 8); spi_bits(8'h55, 8); wt(HP);
    chk(n_bytes == 0 && n_fs == 0, "R4 clocks while deselected", n_bytes, 0);

    // R9 START pattern in SPI mode
    clr(); sck = 1'b1; sda_h = 1'b1; wt(HP); sda_h = 1'b0; wt(HP); sck = 1'b0; wt(HP);
    i2c_byte(8'h7A, a); wt(HP);
    chk(n_fs == 0 && !a && spi_oe == 0, "R9 I2C ignored in SPI mode", n_fs + spi_oe, 0);

    // R9 SPI framing in I2C mode
    mode = 1'b1; sck = 1'b1; sda_h = 1'b1; wt(2 * HP); clr();
    ssb = 1'b0; wt(2 * HP); ssb = 1'b1; wt(2 * HP);
    chk(n_fs == 0 && n_fe == 0, "R9 select ignored in I2C mode", n_fs + n_fe, 0);

    // R7 skip until START, R8 repeated START
    clr();
    i2c_start(); i2c_byte(8'h50, a);
    chk(!a, "R7 foreign address nack", a, 0);
    i2c_byte(8'h7A, a); i2c_byte(8'h12, a);
    chk(!a && n_bytes == 0, "R7 skip until START", n_bytes, 0);
    sda_h = 1'b1; wt(HP); sck = 1'b1; wt(HP); sda_h = 1'b0; wt(HP); sck = 1'b0; wt(HP);
    chk(n_both == 1 && n_fs == 2 && n_fe == 1, "R8 repeated START markers",
        n_both * 100 + n_fs * 10 + n_fe, 121);
    i2c_byte(8'h7A, a);
    chk(a, "R8 new address phase ack", a, 1);
    i2c_byte(8'h9C, a); i2c_stop(); wt(HP);
    chk(a && n_bytes == 1 && log_b[0] == 8'h9C, "R8 data after repeated START", log_b[0], 8'h9C);
    chk(n_fe == 2, "R5 STOP closes frame", n_fe, 2);

    chk(wide == 0, "R10 single cycle pulses", wide, 0);
    chk(spi_oe == 0, "R9 no drive in SPI mode", spi_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule